// File: doc/BRIEF.md
# In-band sync code inserter

The block sits on a parallel pixel path and folds the line-valid and frame-valid qualifiers into the data words. Each clock it takes one raw pixel with line-valid and frame-valid and produces one output word of the same width. Reserved words mark the start of a frame, the start of each further line, the end of each line and the end of a frame. Raw pixels that could be mistaken for those words are rewritten. Cycles with nothing to report carry a fill word.

A pixel counts as active only when line-valid and frame-valid are both high. Internally the input runs through a short delay line. The block can then see a frame start coming and place its four-word preamble ahead of the first pixel. The end code goes out in the first inactive cycle after a line, and it is chosen by looking at frame-valid in that cycle. A downstream decoder recovers line-valid and frame-valid from the word stream alone, so no side-band signals are needed.

Top module: `sync_code_inserter`

## Requirements
- R1: An active pixel with value 0, 1, 2 or 3 is output as 4. Every other active pixel value is output unchanged.
- R2: Three consecutive active pixels 1023, 0, 1023 are output as 1023, 4, 1023.
- R3: The first active pixel after frame-valid was low is preceded, in the four cycles just before it, by the words 1023, 0, 1023, 1.
- R4: Every later line of a frame is preceded, in the cycle just before its first pixel, by the word 1.
- R5: A line whose first inactive cycle still has frame-valid high is followed, in that cycle, by the word 2.
- R6: A line whose first inactive cycle has frame-valid low is the last line of the frame. It is followed, in that cycle, by the word 3.
- R7: Every other output cycle carries 0. This includes cycles where line-valid is high while frame-valid is low; such cycles are ignored.
- R8: The output word for an input cycle appears a fixed LEAD+2 clock cycles later.
- R9: The input must have at least 5 inactive cycles before the first pixel of a frame and at least 2 inactive cycles between lines.
- R10: While reset is asserted, the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | PIX_W (10) | Raw pixel value |
| lv_i | input | 1 | Line valid |
| fv_i | input | 1 | Frame valid |
| word_o | output | PIX_W (10) | Encoded word stream |

## Verification
The bench uses the default 10-bit words and LEAD of 4, so the latency is 6 cycles. With 10-bit words, one 1024-pixel line carries every possible pixel value, which sweeps the substitution rule exhaustively. Further frames cover repeated 1023, 0, 1023 triples and single-pixel lines. Frames are placed exactly at the minimum frame and line gaps, so preamble and end codes sit right next to each other. Line-valid is also pulsed while frame-valid is low, to show that such cycles are ignored.

// File: rtl/sync_ins_pkg.sv
package sync_ins_pkg;
  parameter int unsigned PIX_W = 10;

  typedef logic [PIX_W-1:0] word_t;

  localparam word_t WORD_MAX  = '1;
  localparam word_t CODE_FILL = word_t'(0);
  localparam word_t CODE_SOL  = word_t'(1);
  localparam word_t CODE_EOL  = word_t'(2);
  localparam word_t CODE_EOF  = word_t'(3);
  localparam word_t WORD_SUB  = word_t'(4);

  typedef struct packed {
    word_t pix;
    logic  act;
    logic  fv;
    logic  first;
  } stage_t;
endpackage

// File: rtl/sync_ins_delay.sv
module sync_ins_delay
  import sync_ins_pkg::*;
#(
  parameter int unsigned DEPTH = 6
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  stage_t in_i,
  output stage_t tap_o [DEPTH]
);
  stage_t q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[g] <= '0;
        else         q[g] <= in_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[g] <= '0;
        else         q[g] <= q[g-1];
      end
    end
    assign tap_o[g] = q[g];
  end
endmodule

// File: rtl/sync_ins_scrub.sv
module sync_ins_scrub
  import sync_ins_pkg::*;
(
  input  stage_t cur_i,
  input  stage_t older_i,
  input  stage_t newer_i,
  output word_t  pix_o
);
  logic triple;

  // middle of a max/zero/max run among active pixels
  assign triple = older_i.act && newer_i.act && (older_i.pix == WORD_MAX)
                  && (newer_i.pix == WORD_MAX) && (cur_i.pix == CODE_FILL);

  always_comb begin
    pix_o = cur_i.pix;
    if (cur_i.pix < WORD_SUB) pix_o = WORD_SUB;
    if (triple)               pix_o = WORD_SUB;
  end
endmodule

// File: rtl/sync_ins_code_mux.sv
module sync_ins_code_mux
  import sync_ins_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  act_i,
  input  logic  fv_i,
  input  logic  prev_act_i,
  input  logic  sol_next_i,
  input  logic  sof_in2_i,
  input  logic  sof_in3_i,
  input  logic  sof_in4_i,
  input  word_t pix_i,
  output word_t word_o
);
  word_t word_d, word_q;
  logic  pix_q;

  always_comb begin
    if (act_i)           word_d = pix_i;
    else if (prev_act_i) word_d = fv_i ? CODE_EOL : CODE_EOF;
    else if (sol_next_i) word_d = CODE_SOL;
    else if (sof_in2_i)  word_d = WORD_MAX;
    else if (sof_in3_i)  word_d = CODE_FILL;
    else if (sof_in4_i)  word_d = WORD_MAX;
    else                 word_d = CODE_FILL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= CODE_FILL;
      pix_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      pix_q  <= act_i;
    end
  end

  assign word_o = word_q;

  AST_PIX_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_q |-> word_q >= WORD_SUB); // R1
endmodule

// File: rtl/sync_code_inserter.sv
module sync_code_inserter
  import sync_ins_pkg::*;
#(
  parameter int unsigned LEAD = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             lv_i,
  input  logic             fv_i,
  output logic [PIX_W-1:0] word_o
);
  localparam int unsigned DEPTH = LEAD + 2;
  localparam int unsigned OUT   = LEAD;

  logic   pend_q;
  stage_t in_s;
  stage_t tap [DEPTH];
  word_t  pix_clean;
  logic   sol0, sol_next, sof2, sof3, sof4;

  // set during frame blanking, cleared by the first active pixel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b1;
    else if (!fv_i) pend_q <= 1'b1;
    else if (lv_i)  pend_q <= 1'b0;
  end

  always_comb begin
    in_s.pix   = pix_i;
    in_s.act   = lv_i & fv_i;
    in_s.fv    = fv_i;
    in_s.first = pend_q;
  end

  sync_ins_delay #(.DEPTH(DEPTH)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (in_s),
    .tap_o  (tap)
  );

  assign sol0     = tap[0].act & ~tap[1].act;
  assign sol_next = tap[OUT-1].act & ~tap[OUT].act;
  assign sof2 = tap[OUT-2].act & ~tap[OUT-1].act & tap[OUT-2].first;
  assign sof3 = tap[OUT-3].act & ~tap[OUT-2].act & tap[OUT-3].first;
  assign sof4 = tap[OUT-4].act & ~tap[OUT-3].act & tap[OUT-4].first;

  sync_ins_scrub u_scrub (
    .cur_i   (tap[OUT]),
    .older_i (tap[OUT+1]),
    .newer_i (tap[OUT-1]),
    .pix_o   (pix_clean)
  );

  sync_ins_code_mux u_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (tap[OUT].act),
    .fv_i       (tap[OUT].fv),
    .prev_act_i (tap[OUT+1].act),
    .sol_next_i (sol_next),
    .sof_in2_i  (sof2),
    .sof_in3_i  (sof3),
    .sof_in4_i  (sof4),
    .pix_i      (pix_clean),
    .word_o     (word_o)
  );

  AST_CLAMP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap[OUT].act && tap[OUT].pix < WORD_SUB) |=> word_o == WORD_SUB); // R1
  AST_PREAMBLE_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof4 |=> word_o == WORD_MAX); // R3
  AST_END_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tap[OUT].act && tap[OUT+1].act) |=> (word_o == CODE_EOL || word_o == CODE_EOF)); // R5
  AST_LINE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sol0 |-> !tap[2].act); // R9
  AST_FRAME_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sol0 && tap[0].first) |-> (!tap[2].act && !tap[3].act && !tap[4].act && !tap[5].act)); // R9
endmodule

// File: tb/sync_code_inserter_tb.sv
`timescale 1ns/1ps
module sync_code_inserter_tb;
  localparam int LEAD = 4;
  localparam int LAT  = LEAD + 2;
  localparam int NCYC = 8192;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] pix_i = '0;
  logic       lv_i = 1'b0;
  logic       fv_i = 1'b0;
  logic [9:0] word_o;

  int checks = 0;
  int errors = 0;
  int m = 0;
  int exp_w [NCYC];
  int exp_r [NCYC];

  always #2 clk = ~clk;

  sync_code_inserter #(.LEAD(LEAD)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pix_i(pix_i),
    .lv_i(lv_i), .fv_i(fv_i), .word_o(word_o)
  );

  task automatic check(input int act, input int expv, input int req);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL R%0d cycle %0d actual %0d expected %0d", req, m, act, expv);
    end
  endtask

  // sample first, then drive; output of input cycle n is read LAT cycles later (R8)
  task automatic step(input int p, input logic lv, input logic fv);
    @(negedge clk);
    if (m >= LAT) check(int'(word_o), exp_w[m-LAT], exp_r[m-LAT]);
    pix_i = p[9:0];
    lv_i  = lv;
    fv_i  = fv;
    m++;
  endtask

  function automatic int val(input int kind, input int l, input int w);
    int pat [8] = '{1023, 0, 1023, 2, 3, 1, 5, 1022};
    if (kind == 0) return w % 1024;
    if (kind == 1) return pat[(w + l) % 8];
    return (l * 37 + w * 11 + 3) % 1024;
  endfunction

  task automatic frame(input int nl, input int wd, input int gap, input int vb, input int kind);
    for (int i = 0; i < vb; i++) begin
      exp_w[m] = 0; exp_r[m] = 7; // R7: lv pulses with fv low are ignored
      step(i + 600, (i % 3 == 1), 1'b0);
    end
    for (int l = 0; l < nl; l++) begin
      for (int w = 0; w < wd; w++) begin
        int v = val(kind, l, w);
        if (w == 0) begin
          if (l == 0) begin // R3 preamble
            exp_w[m-4] = 1023; exp_r[m-4] = 3;
            exp_w[m-3] = 0;    exp_r[m-3] = 3;
            exp_w[m-2] = 1023; exp_r[m-2] = 3;
            exp_w[m-1] = 1;    exp_r[m-1] = 3;
          end else begin    // R4 line start
            exp_w[m-1] = 1;    exp_r[m-1] = 4;
          end
        end
        exp_w[m] = (v < 4) ? 4 : v;
        exp_r[m] = (kind == 2) ? 8 : 1; // R1 clamp, R8 alignment
        if (w > 0 && w < wd - 1 && val(kind, l, w-1) == 1023 && v == 0
            && val(kind, l, w+1) == 1023) exp_r[m] = 2; // R2 triple
        step(v, 1'b1, 1'b1);
      end
      for (int g = 0; g < gap; g++) begin
        bit last = (l == nl - 1);
        if (g == 0) begin
          exp_w[m] = last ? 3 : 2;  // R6 frame end, R5 line end
          exp_r[m] = last ? 6 : 5;
        end else begin
          exp_w[m] = 0; exp_r[m] = 7; // R7 fill
        end
        step(0, 1'b0, !last);
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCYC; i++) begin
      exp_w[i] = 0;
      exp_r[i] = 7;
    end
    // R10 reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (word_o != 10'd0) begin
        errors++;
        $display("FAIL R10 actual %0d expected 0", word_o);
      end
    end
    @(negedge clk);
    rst_ni = 1'b1;
    frame(1, 1024, 2, 6, 0);   // every pixel value, single-line frame
    frame(3, 9, 2, 5, 1);      // triples and low values, minimum gaps (R9)
    frame(2, 1, 3, 5, 2);      // one-pixel lines
    frame(4, 17, 4, 8, 2);
    for (int i = 0; i < LAT + 2; i++) begin
      exp_w[m] = 0; exp_r[m] = 7;
      step(0, 1'b0, 1'b0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule